// File: doc/BRIEF.md
# I2C Target with Byte-Addressed Memory

This block is an I2C target that puts an internal byte memory of 2^MEM_AW locations (8192 bytes by default) on a two-wire bus. SCL and SDA are brought into the system clock domain, and START and STOP are found there. After a START, the first byte selects the device. It is a fixed four-bit family code followed by three strap bits and the direction bit. In a write, two address bytes load the pointer and every later byte is stored. In a read, bytes are returned from the pointer until the master stops acknowledging.

Writes take effect as soon as their byte ends, so the target is never busy. A new transfer may begin right after a write and is acknowledged. A protect input blocks every store but leaves reads untouched. SDA is driven only through an open-drain pull-low enable, which the chip pad turns into a low level.

Top module: `i2c_byte_memory`

## Requirements
- R1: The first byte after START is compared MSB first: bits 7..4 must be 1010, bits 3..1 must equal strap_i[2:0], and bit 0 is the direction (0 write, 1 read). On a match, sda_oe_o pulls SDA low during the 9th SCL clock. On a mismatch SDA stays released, and the target ignores the bus until the next START.
- R2: In a write, the two bytes after the device byte form the address, high byte first. Each is acknowledged, and only the low MEM_AW bits (13 by default) select a location.
- R3: Each data byte that follows the address in a write is acknowledged on its 9th clock and stored at the pointer.
- R4: In a read, the target drives the addressed byte MSB first, one bit per SCL clock, and releases SDA during the 9th clock so that it can sample the master's acknowledge.
- R5: A read that follows the device byte directly, with no address phase before it, returns the byte at the current pointer.
- R6: The pointer rises by one after every data byte, read or written, and wraps from the last location (0x1FFF by default) to 0x0000.
- R7: While wp_i is 1, write data bytes are still acknowledged and still advance the pointer, but nothing is stored. Reads are unaffected by wp_i.
- R8: SDA is only ever pulled low, and sda_oe_o is raised only while SCL is low.
- R9: A START seen in any state returns the target to device matching. A repeated START after an address phase therefore gives a read from that address.
- R10: When the master does not acknowledge a read byte, the target releases SDA and stays silent until START or STOP. A STOP always releases SDA.
- R11: A write is never busy. A device byte sent at once after a stored byte, through a repeated START or through STOP then START, is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Chip-select straps matched against device byte bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks all stores |

## Verification
Two functions can fall on the same SCL fall. At the end of a write byte the store, the pointer step and the start of the acknowledge all happen together. The bench aims this at the last location so that the store and the wrap coincide, then reads back both 0x1FFF and 0x0000. In a sequential read, the master's acknowledge sample is followed on that clock's fall by the release of the acknowledge slot and the loading of the next byte onto SDA. This is judged by reading consecutive bytes and comparing each one, and by checking that SDA stays released after a not-acknowledge.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    localparam logic [3:0] FAMILY_CODE = 4'b1010;
    localparam int         BYTE_W      = 8;
    localparam logic [3:0] ACK_SLOT    = 4'd8;
    localparam logic [3:0] FRAME_END   = 4'd9;

endpackage

// File: rtl/i2cmem_line_sampler.sv
module i2cmem_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (SYNC_STAGES > 1) begin
            s_d.scl_pipe = {s_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
            s_d.sda_pipe = {s_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        end else begin
            s_d.scl_pipe = SYNC_STAGES'(scl_i);
            s_d.sda_pipe = SYNC_STAGES'(sda_i);
        end
        s_d.scl_prev = s_q.scl_pipe[LAST];
        s_d.sda_prev = s_q.sda_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o      = s_q.scl_pipe[LAST];
    assign sda_o      = s_q.sda_pipe[LAST];
    assign scl_rise_o = s_q.scl_pipe[LAST] & ~s_q.scl_prev;
    assign scl_fall_o = ~s_q.scl_pipe[LAST] & s_q.scl_prev;
    assign start_o    = s_q.scl_pipe[LAST] & s_q.scl_prev & s_q.sda_prev & ~s_q.sda_pipe[LAST];
    assign stop_o     = s_q.scl_pipe[LAST] & s_q.scl_prev & ~s_q.sda_prev & s_q.sda_pipe[LAST];

    // R9 / R10: START and STOP need SCL held high, so neither can coincide with an SCL edge
    assert_cond_excl_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));

endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
    import i2cmem_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              drive_low_o,
    output logic              we_o,
    output logic [AW-1:0]     waddr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic [AW-1:0]     raddr_o
);

    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shreg;
        logic              drv;
        logic              rw;
        logic              mack;
        logic [BYTE_W-1:0] ahi;
        logic [AW-1:0]     ptr;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [2*BYTE_W-1:0] full_addr;
    logic                dev_hit;

    assign full_addr = {s_q.ahi, s_q.shreg};
    assign dev_hit   = (s_q.shreg[7:4] == FAMILY_CODE) && (s_q.shreg[3:1] == strap_i);

    always_comb begin
        s_d     = s_q;
        we_o    = 1'b0;
        waddr_o = s_q.ptr;
        wdata_o = s_q.shreg;
        if (start_i) begin
            s_d.phase = PH_DEV;
            s_d.cnt   = '0;
            s_d.drv   = 1'b0;
        end else if (stop_i) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            s_d.drv   = 1'b0;
        end else if (s_q.phase != PH_IDLE) begin
            if (scl_rise_i) begin
                if (s_q.cnt == ACK_SLOT) begin
                    s_d.cnt  = FRAME_END;
                    s_d.mack = ~sda_s_i;
                end else if (s_q.cnt < ACK_SLOT) begin
                    s_d.cnt = s_q.cnt + 4'd1;
                    if (s_q.phase != PH_RD) begin
                        s_d.shreg = {s_q.shreg[BYTE_W-2:0], sda_s_i};
                    end
                end
            end else if (scl_fall_i) begin
                if (s_q.cnt == ACK_SLOT) begin
                    unique case (s_q.phase)
                        PH_DEV: begin
                            if (dev_hit) begin
                                s_d.drv = 1'b1;
                                s_d.rw  = s_q.shreg[0];
                            end else begin
                                s_d.phase = PH_IDLE;
                                s_d.cnt   = '0;
                                s_d.drv   = 1'b0;
                            end
                        end
                        PH_AHI: begin
                            s_d.drv = 1'b1;
                            s_d.ahi = s_q.shreg;
                        end
                        PH_ALO: begin
                            s_d.drv = 1'b1;
                            s_d.ptr = full_addr[AW-1:0];
                        end
                        PH_WR: begin
                            s_d.drv = 1'b1;
                            we_o    = ~wp_i;
                            s_d.ptr = s_q.ptr + PTR_ONE;
                        end
                        PH_RD: begin
                            s_d.drv = 1'b0;
                        end
                        default: begin
                            s_d.drv = 1'b0;
                        end
                    endcase
                end else if (s_q.cnt == FRAME_END) begin
                    s_d.cnt = '0;
                    s_d.drv = 1'b0;
                    unique case (s_q.phase)
                        PH_DEV: begin
                            if (s_q.rw) begin
                                s_d.phase = PH_RD;
                                s_d.shreg = rdata_i;
                                s_d.drv   = ~rdata_i[BYTE_W-1];
                                s_d.ptr   = s_q.ptr + PTR_ONE;
                            end else begin
                                s_d.phase = PH_AHI;
                            end
                        end
                        PH_AHI: s_d.phase = PH_ALO;
                        PH_ALO: s_d.phase = PH_WR;
                        PH_WR:  s_d.phase = PH_WR;
                        PH_RD: begin
                            if (s_q.mack) begin
                                s_d.shreg = rdata_i;
                                s_d.drv   = ~rdata_i[BYTE_W-1];
                                s_d.ptr   = s_q.ptr + PTR_ONE;
                            end else begin
                                s_d.phase = PH_IDLE;
                            end
                        end
                        default: s_d.phase = PH_IDLE;
                    endcase
                end else if (s_q.phase == PH_RD && s_q.cnt != 4'd0) begin
                    s_d.shreg = {s_q.shreg[BYTE_W-2:0], 1'b0};
                    s_d.drv   = ~s_q.shreg[BYTE_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign drive_low_o = s_q.drv;
    assign raddr_o     = s_q.ptr;

    // R9: a START puts the target back at bit zero of device matching with SDA released
    assert_start_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (s_q.phase == PH_DEV && s_q.cnt == 4'd0 && !s_q.drv));

    // R10: a STOP releases SDA and parks the target
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (s_q.phase == PH_IDLE && !s_q.drv));

    // R10: a not-acknowledged read byte ends with SDA released
    assert_nack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall_i && s_q.cnt == FRAME_END && s_q.phase == PH_RD && !s_q.mack)
        |=> (!s_q.drv && s_q.phase == PH_IDLE));

    // R6: every written byte moves the pointer on by exactly one, modulo the array size
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall_i && s_q.cnt == ACK_SLOT && s_q.phase == PH_WR)
        |=> (s_q.ptr == $past(s_q.ptr) + PTR_ONE));

    // R4: SDA is free for the master during the read acknowledge slot
    assert_read_ack_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RD && s_q.cnt == FRAME_END) |-> !s_q.drv);

endmodule

// File: rtl/i2c_byte_memory.sv
module i2c_byte_memory #(
    parameter int MEM_AW      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int DW = i2cmem_pkg::BYTE_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0]     mem_wdata, mem_rdata;

    i2cmem_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    i2cmem_ctrl #(
        .AW(MEM_AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .strap_i    (strap_i),
        .wp_i       (wp_i),
        .rdata_i    (mem_rdata),
        .drive_low_o(sda_oe_o),
        .we_o       (mem_we),
        .waddr_o    (mem_waddr),
        .wdata_o    (mem_wdata),
        .raddr_o    (mem_raddr)
    );

    i2cmem_array #(
        .AW(MEM_AW),
        .DW(DW)
    ) u_array (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(mem_wdata),
        .raddr_i(mem_raddr),
        .rdata_o(mem_rdata)
    );

    // R7: the array never sees a store while protection is on
    assert_no_store_protected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_i);

    // R8: the pull-down is engaged only while the sampled SCL is low
    assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(scl_s));

endmodule

// File: tb/i2c_byte_memory_bench.sv
module i2c_byte_memory_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       sda_bus;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    i2c_byte_memory u_i2c_byte_memory (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .sda_oe_o(sda_oe),
        .strap_i (strap),
        .wp_i    (wp)
    );

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_low = 1'b0; q();
        m_scl = 1'b1; q();
        m_low = 1'b1; q();
        m_scl = 1'b0; q();
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; q();
        m_scl = 1'b1; q();
        m_low = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; q();
            m_scl = 1'b1; q(); q();
            m_scl = 1'b0; q();
        end
        m_low = 1'b0; q();
        m_scl = 1'b1; q();
        acked = ~sda_bus; q();
        m_scl = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q();
            m_scl = 1'b1; q();
            b[i] = sda_bus; q();
            m_scl = 1'b0;
        end
        q();
        m_low = give_ack; q();
        m_scl = 1'b1; q(); q();
        m_scl = 1'b0; q();
        m_low = 1'b0;
    endtask

    task automatic set_pointer(input logic [15:0] a, input string req);
        logic ak;
        i2c_start();
        send_byte(DEV_W, ak);  chk({req, " device ack"}, ak, 1);
        send_byte(a[15:8], ak); chk({req, " high address ack"}, ak, 1);
        send_byte(a[7:0], ak);  chk({req, " low address ack"}, ak, 1);
    endtask

    task automatic read_from(input logic [15:0] a, input int n, input logic [7:0] e0,
                             input logic [7:0] e1, input string req);
        logic       ak;
        logic [7:0] d;
        set_pointer(a, req);
        i2c_start();
        send_byte(DEV_R, ak); chk({req, " read device ack"}, ak, 1);
        recv_byte(d, n > 1); chk({req, " first byte"}, d, e0);
        if (n > 1) begin
            recv_byte(d, 1'b0); chk({req, " second byte"}, d, e1);
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        chk("R8 released after reset", sda_oe, 0);
    endtask

    task automatic t_wrong_device();
        logic ak;
        i2c_start();
        send_byte(8'hA4, ak);
        chk("R1 mismatched straps not acked", ak, 0);
        send_byte(8'h00, ak);
        chk("R1 ignored after mismatch", ak, 0);
        i2c_stop();
    endtask

    task automatic t_write_block();
        logic ak;
        set_pointer(16'h0123, "R2");
        send_byte(8'h5A, ak); chk("R3 data ack 0", ak, 1);
        send_byte(8'hC3, ak); chk("R3 data ack 1", ak, 1);
        send_byte(8'h7E, ak); chk("R3 data ack 2", ak, 1);
        i2c_stop();
    endtask

    task automatic t_random_read();
        logic       ak;
        logic [7:0] d;
        set_pointer(16'h0123, "R9");
        i2c_start();
        send_byte(DEV_R, ak); chk("R9 repeated start read ack", ak, 1);
        recv_byte(d, 1'b1); chk("R4 byte 0x0123", d, 8'h5A);
        recv_byte(d, 1'b1); chk("R6 byte 0x0124", d, 8'hC3);
        recv_byte(d, 1'b0); chk("R6 byte 0x0125", d, 8'h7E);
        i2c_stop();
    endtask

    task automatic t_current_read();
        logic       ak;
        logic [7:0] d;
        set_pointer(16'h0124, "R5");
        i2c_stop();
        i2c_start();
        send_byte(DEV_R, ak); chk("R5 current read ack", ak, 1);
        recv_byte(d, 1'b1); chk("R5 byte at pointer", d, 8'hC3);
        recv_byte(d, 1'b0); chk("R6 next byte", d, 8'h7E);
        i2c_stop();
    endtask

    task automatic t_protect();
        logic ak;
        wp = 1'b1;
        set_pointer(16'h0124, "R7");
        send_byte(8'hEE, ak); chk("R7 protected byte acked", ak, 1);
        i2c_stop();
        read_from(16'h0124, 1, 8'hC3, 8'h00, "R7 read under protect");
        wp = 1'b0;
    endtask

    task automatic t_high_bits();
        logic ak;
        set_pointer(16'hE123, "R2 upper bits");
        send_byte(8'h99, ak); chk("R2 data ack", ak, 1);
        i2c_stop();
        read_from(16'h0123, 1, 8'h99, 8'h00, "R2 upper bits dropped");
    endtask

    task automatic t_wrap();
        logic ak;
        set_pointer(16'h1FFF, "R6 wrap");
        send_byte(8'h11, ak); chk("R6 last location ack", ak, 1);
        send_byte(8'h22, ak); chk("R6 wrapped ack", ak, 1);
        i2c_stop();
        read_from(16'h1FFF, 2, 8'h11, 8'h22, "R6 read across wrap");
        read_from(16'h0000, 1, 8'h22, 8'h00, "R6 location zero");
    endtask

    task automatic t_master_nack();
        logic       ak;
        logic [7:0] d;
        logic       low_seen;
        set_pointer(16'h0125, "R10");
        i2c_start();
        send_byte(DEV_R, ak); chk("R10 read ack", ak, 1);
        recv_byte(d, 1'b0); chk("R10 byte", d, 8'h7E);
        low_seen = 1'b0;
        for (int i = 0; i < 9; i++) begin
            q();
            m_scl = 1'b1; q();
            if (!sda_bus) low_seen = 1'b1;
            q();
            m_scl = 1'b0;
        end
        q();
        chk("R10 silent after nack", low_seen, 0);
        i2c_stop();
        chk("R10 released after stop", sda_oe, 0);
    endtask

    task automatic t_back_to_back();
        logic       ak;
        logic [7:0] d;
        set_pointer(16'h0200, "R11");
        send_byte(8'h31, ak); chk("R11 data ack", ak, 1);
        i2c_start();
        send_byte(DEV_W, ak); chk("R11 immediate repeated start ack", ak, 1);
        send_byte(8'h02, ak); chk("R11 addr high", ak, 1);
        send_byte(8'h00, ak); chk("R11 addr low", ak, 1);
        i2c_start();
        send_byte(DEV_R, ak); chk("R11 read ack", ak, 1);
        recv_byte(d, 1'b0); chk("R11 stored byte", d, 8'h31);
        i2c_stop();
        set_pointer(16'h0201, "R11 second");
        send_byte(8'h47, ak); chk("R11 second data ack", ak, 1);
        i2c_stop();
        i2c_start();
        send_byte(DEV_W, ak); chk("R11 start after stop ack", ak, 1);
        i2c_stop();
        read_from(16'h0201, 1, 8'h47, 8'h00, "R3 second byte stored");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        q();
        t_reset();
        t_wrong_device();
        t_write_block();
        t_random_read();
        t_current_read();
        t_protect();
        t_high_bits();
        t_wrap();
        t_master_nack();
        t_back_to_back();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule